// File: doc/BRIEF.md
# Multi-Mode Built-In Test Register

This block is a register of configurable width that serves several test roles from two mode pins. In normal operation it captures its parallel input on each clock and presents it on its parallel output, so it can sit between two combinational blocks as an ordinary pipeline register. During test it can take one of three other roles. It can act as a serial scan chain, so it can be chained with other instances through the serial pins. It can act as a multiple-input signature register that folds the parallel inputs into a linear feedback shift register. It can also clear itself synchronously.

When its parallel inputs are held at zero in signature mode, the register runs freely as a maximal-length LFSR. It then serves as a pseudo-random pattern source for the logic it drives. The feedback polynomial is primitive: it is taken from a built-in table for widths 2 to 16, or it is given as an explicit tap mask.

Top module: `bilbo_reg`

## Requirements
- R1: With mode_c1=1 and mode_c0=0 (clear), every stage and scan_out are 0 after the next rising clock edge, whatever the other inputs are.
- R2: With mode_c1=1 and mode_c0=1 (load), par_out equals the par_in sampled at the previous rising edge.
- R3: With mode_c1=0 and mode_c0=0 (shift), stage 0 takes scan_in and stage i takes stage i-1. scan_out is the last stage. No feedback is applied, so shifting in W zeros empties the register.
- R4: With mode_c1=0 and mode_c0=1 (signature), stage i>0 takes stage i-1 XOR par_in[i], and stage 0 takes the feedback XOR par_in[0]. For W=8 the feedback is stage7^stage5^stage4^stage3.
- R5: In signature mode with par_in held at 0, a nonzero W=8 seed comes back after exactly 255 clocks and never passes through zero.
- R6: For W=3 with the state written as stage0 stage1 stage2, a seed of 100 steps through 110, 111, 011, 101, 010, 001 and back to 100 (feedback stage2^stage0).
- R7: In signature mode, an all-zero register with par_in at 0 stays all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mode_c0 | input | 1 | Mode select bit 0 |
| mode_c1 | input | 1 | Mode select bit 1 |
| par_in | input | WIDTH | Parallel data / signature input |
| par_out | output | WIDTH | Register contents |
| scan_in | input | 1 | Serial input to stage 0 |
| scan_out | output | 1 | Serial output from last stage |

## Verification
The hardest condition to reach is the full-period claim. It can only be shown by letting the register run free for 2^W-1 clocks and proving that the seed does not come back earlier. The bench seeds the register through load mode and switches to signature mode with zero inputs. It then counts clocks until the seed comes back, and it checks every step for the all-zero lock-up state. A separate 3-bit instance is checked state by state against the published cycle.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

   typedef enum logic [1:0] {
      MODE_SHIFT = 2'b00,
      MODE_SIG   = 2'b01,
      MODE_CLEAR = 2'b10,
      MODE_LOAD  = 2'b11
   } bilbo_mode_e;

   localparam int MIN_TABLE_W = 2;
   localparam int MAX_TABLE_W = 16;

   // Primitive feedback masks: bit k set means stage k feeds the XOR.
   function automatic logic [63:0] table_taps(input int w);
      logic [63:0] m;
      m = '0;
      case (w)
         2:  m = 64'h0003;
         3:  m = 64'h0005;
         4:  m = 64'h0009;
         5:  m = 64'h0012;
         6:  m = 64'h0021;
         7:  m = 64'h0041;
         8:  m = 64'h00B8;
         9:  m = 64'h0108;
         10: m = 64'h0204;
         11: m = 64'h0402;
         12: m = 64'h0829;
         13: m = 64'h100D;
         14: m = 64'h2015;
         15: m = 64'h4001;
         16: m = 64'hD008;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = '0
) (
   input  logic [WIDTH-1:0] state,
   output logic             fb
);
   localparam int NTAPS = $countones(TAPS);

   generate
      if (NTAPS == 2) begin : g_pair
         localparam int HI = WIDTH - 1;
         logic [WIDTH-1:0] low_mask;
         assign low_mask = TAPS & ~(WIDTH'(1) << HI);
         assign fb = state[HI] ^ (|(state & low_mask));
      end else begin : g_tree
         assign fb = ^(state & TAPS);
      end
   endgenerate
endmodule

// File: rtl/bilbo_stage.sv
module bilbo_stage
   import bilbo_pkg::*;
(
   input  logic        clk,
   input  bilbo_mode_e mode,
   input  logic        d,
   input  logic        chain,
   output logic        q
);
   always_ff @(posedge clk) begin
      unique case (mode)
         MODE_CLEAR: q <= 1'b0;
         MODE_LOAD:  q <= d;
         MODE_SHIFT: q <= chain;
         MODE_SIG:   q <= chain ^ d;
         default:    q <= 1'b0;
      endcase
   end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
   import bilbo_pkg::*;
#(
   parameter int               WIDTH    = 8,
   parameter logic [WIDTH-1:0] TAP_MASK = '0
) (
   input  logic             clk,
   input  logic             mode_c0,
   input  logic             mode_c1,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] par_out,
   input  logic             scan_in,
   output logic             scan_out
);
   localparam logic [63:0]      TABLE_MASK = table_taps(WIDTH);
   localparam bit               USE_TABLE  = (TAP_MASK == '0);
   localparam logic [WIDTH-1:0] TAPS       = USE_TABLE ? TABLE_MASK[WIDTH-1:0] : TAP_MASK;

   generate
      if (WIDTH < MIN_TABLE_W) begin : g_bad_width
         $error("bilbo_reg: WIDTH must be at least %0d", MIN_TABLE_W);
      end
      if (USE_TABLE && WIDTH > MAX_TABLE_W) begin : g_no_table
         $error("bilbo_reg: no built-in taps above width %0d, give TAP_MASK", MAX_TABLE_W);
      end
      if (!TAPS[WIDTH-1]) begin : g_bad_taps
         $error("bilbo_reg: tap mask must include the last stage");
      end
   endgenerate

   bilbo_mode_e      mode;
   logic             fb;
   logic             head;
   logic [WIDTH-1:0] chain;
   logic [WIDTH-1:0] q;

   assign mode = bilbo_mode_e'({mode_c1, mode_c0});

   bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
      .state(q),
      .fb   (fb)
   );

   assign head = (mode == MODE_SHIFT) ? scan_in : fb;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign chain[i] = head;
         end else begin : g_body
            assign chain[i] = q[i-1];
         end
         bilbo_stage u_stage (
            .clk  (clk),
            .mode (mode),
            .d    (par_in[i]),
            .chain(chain[i]),
            .q    (q[i])
         );
      end
   endgenerate

   assign par_out  = q;
   assign scan_out = q[WIDTH-1];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             mode_c0,
   input logic             mode_c1,
   input logic [WIDTH-1:0] par_in,
   input logic [WIDTH-1:0] par_out,
   input logic             scan_in,
   input logic             scan_out
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R1
   a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
      (mode_c1 && !mode_c0) |=> (par_out == '0 && !scan_out));

   // R2
   a_r2_load: assert property (@(posedge clk) disable iff (!armed)
      (mode_c1 && mode_c0) |=> (par_out == $past(par_in)));

   // R3
   a_r3_shift: assert property (@(posedge clk) disable iff (!armed)
      (!mode_c1 && !mode_c0) |=>
         (par_out[0] == $past(scan_in) && par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0])));

   // R4
   a_r4_sig_body: assert property (@(posedge clk) disable iff (!armed)
      (!mode_c1 && mode_c0) |=>
         (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0] ^ par_in[WIDTH-1:1])));

   // R7
   a_r7_zero_lock: assert property (@(posedge clk) disable iff (!armed)
      (!mode_c1 && mode_c0 && par_out == '0 && par_in == '0) |=> (par_out == '0));
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .mode_c0 (mode_c0),
   .mode_c1 (mode_c1),
   .par_in  (par_in),
   .par_out (par_out),
   .scan_in (scan_in),
   .scan_out(scan_out)
);

// File: tb/bilbo_reg_test.sv
`timescale 1ns/1ps
module bilbo_reg_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         c0 = 1'b0, c1 = 1'b1;
   logic [W-1:0] pin = '0;
   logic         sin = 1'b0;
   logic [W-1:0] pout;
   logic         sout;

   logic         m0 = 1'b0, m1 = 1'b1;
   logic [2:0]   pin3 = '0;
   logic [2:0]   pout3;
   logic         sout3;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bilbo_reg #(.WIDTH(W)) uut (
      .clk(clk), .mode_c0(c0), .mode_c1(c1), .par_in(pin),
      .par_out(pout), .scan_in(sin), .scan_out(sout)
   );

   bilbo_reg #(.WIDTH(3)) uut_w3 (
      .clk(clk), .mode_c0(m0), .mode_c1(m1), .par_in(pin3),
      .par_out(pout3), .scan_in(1'b0), .scan_out(sout3)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive on negedge, one rising edge, sample at following negedge.
   task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic s);
      {c1, c0} = m;
      pin = d;
      sin = s;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] sig_next(input logic [W-1:0] q, input logic [W-1:0] d);
      logic f;
      f = q[7] ^ q[5] ^ q[4] ^ q[3];
      return {q[W-2:0], f} ^ d;
   endfunction

   task automatic t_clear;
      step(2'b11, 8'hA5, 1'b1);
      step(2'b10, 8'hFF, 1'b1);
      chk("R1 clear par_out", pout, 0);
      chk("R1 clear scan_out", sout, 0);
   endtask

   task automatic t_load;
      step(2'b11, 8'h3C, 1'b0);
      chk("R2 load 3C", pout, 8'h3C);
      step(2'b11, 8'hC3, 1'b1);
      chk("R2 load C3", pout, 8'hC3);
   endtask

   task automatic t_shift;
      logic [W-1:0] pat = 8'b1011_0010;
      step(2'b10, 8'h00, 1'b0);
      for (int k = W - 1; k >= 0; k--) step(2'b00, 8'hFF, pat[k]);
      chk("R3 shift in pattern", pout, pat);
      chk("R3 scan_out is last stage", sout, pat[W-1]);
      for (int k = 0; k < W; k++) begin
         chk("R3 serial out bit", sout, pat[W-1-k]);
         step(2'b00, 8'h00, 1'b0);
      end
      chk("R3 no feedback after zeros", pout, 0);
   endtask

   task automatic t_sig;
      logic [W-1:0] exp = 8'h5A;
      logic [W-1:0] ins[6] = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'h37, 8'hE4};
      step(2'b11, 8'h5A, 1'b0);
      foreach (ins[k]) begin
         exp = sig_next(exp, ins[k]);
         step(2'b01, ins[k], 1'b1);
         chk("R4 signature step", pout, exp);
      end
   endtask

   task automatic t_prpg;
      int  n = 0;
      bit  hit_zero = 0;
      step(2'b11, 8'h01, 1'b0);
      do begin
         step(2'b01, 8'h00, 1'b0);
         n++;
         if (pout == 0) hit_zero = 1;
      end while (pout != 8'h01 && n < 300);
      chk("R5 period", n, 255);
      chk("R5 never zero", hit_zero, 0);
   endtask

   task automatic t_zero;
      step(2'b10, 8'h00, 1'b0);
      step(2'b01, 8'h00, 1'b0);
      step(2'b01, 8'h00, 1'b0);
      chk("R7 zero lock-up", pout, 0);
   endtask

   task automatic t_w3;
      // bit0 = stage0, so written state 100 is 3'b001
      logic [2:0] seq[7] = '{3'b011, 3'b111, 3'b110, 3'b101, 3'b010, 3'b100, 3'b001};
      {m1, m0} = 2'b11; pin3 = 3'b001;
      @(negedge clk);
      chk("R6 seed", pout3, 3'b001);
      {m1, m0} = 2'b01; pin3 = 3'b000;
      foreach (seq[k]) begin
         @(negedge clk);
         chk("R6 state order", pout3, seq[k]);
      end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_clear();
      t_load();
      t_shift();
      t_sig();
      t_prpg();
      t_zero();
      t_w3();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule